// File: doc/BRIEF.md
# Automatic Multi-Byte Serial Transfer Engine

This block is a three-wire synchronous serial master with a serial clock output, a data output and a data input. It moves a burst of bytes between its own small buffer RAM and the serial lines without any action per byte from the processor. Software fills the buffer through a simple write port, chooses the burst length, the inter-byte gap and the serial clock rate, sets the enable input, and then pulses the start strobe.

A hardware sequencer then works through the buffer from address 0. For each byte it fetches the byte, shifts it out most significant bit first while it shifts in the reply, and writes the reply over the byte it just sent. It then holds the serial clock idle for the programmed gap before it starts the next byte. A busy flag stays high for the whole burst. A single-cycle interrupt pulse, together with a sticky flag that an acknowledge input clears, marks the end of the burst. Software should poll the busy flag to learn that the burst is done, because the sticky flag goes away once it is acknowledged.

Top module: `ase_burst_top`

## Requirements
- R1: Bytes are sent on `sdo` most significant bit first, starting with buffer address 0 and going up by one per byte, for `byte_cnt` bytes. A bit is valid at each rising edge of `sck`.
- R2: The byte received on `sdi`, whose first bit is the most significant, is written over the buffer address it was sent from. Addresses at and above `byte_cnt` are left unchanged.
- R3: A `start` pulse while `en` is 0 starts nothing: `busy` stays 0 and `sck` stays high.
- R4: `irq` is high for exactly one cycle per completed burst. That cycle is the first cycle in which `busy` is 0 after the last byte, and `irq` never pulses between bytes.
- R5: `irq_flag` is set together with `irq` and stays at 1 until `irq_ack` is pulsed. It is 0 in the cycle after the acknowledge.
- R6: `busy` rises in the cycle after an accepted `start` and falls exactly once per burst, after the last byte.
- R7: `sck` idles high. While a byte is shifting, each low phase and each high phase lasts `half_div` system clock cycles (`half_div` >= 1).
- R8: Between two bytes of a burst, `sck` stays high for exactly `gap_cyc` + `half_div` + 4 system clock cycles, counted from the last rising edge of one byte to the first falling edge of the next.
- R9: Once `busy` has been 0 for two consecutive cycles, `sdo` is 0.
- R10: A `start` pulse while `busy` is 1 is ignored: the running burst keeps its length, and only one `irq` is produced.
- R11: Driving `en` to 0 during a burst aborts it. In the next cycle `busy` is 0, `sck` is 1 and `sdo` is 0, and no `irq` follows.
- R12: A `start` with `byte_cnt` equal to 0 starts nothing. Burst lengths from 1 up to the full buffer depth are supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low aborts a running burst |
| start | input | 1 | One-cycle trigger strobe |
| byte_cnt | input | 6 | Burst length in bytes, latched at start |
| gap_cyc | input | 8 | Extra idle cycles after each byte, latched at start |
| half_div | input | 8 | Serial clock half period in system cycles, latched at start |
| irq_ack | input | 1 | Clears the sticky interrupt flag |
| buf_we | input | 1 | Buffer write strobe for the software port |
| buf_addr | input | 5 | Buffer address for the software port |
| buf_wdata | input | 8 | Buffer write data for the software port |
| buf_rdata | output | 8 | Buffer read data, one cycle after the address |
| sck | output | 1 | Serial clock, idle high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | High for the whole burst |
| irq | output | 1 | One-cycle end-of-burst pulse |
| irq_flag | output | 1 | Sticky end-of-burst flag |

## Verification
If the buffer pointer or the byte counter goes wrong, a byte on `sdo` arrives out of order or a burst has the wrong length, and this shows within one byte time of the fault. A wrong shift register direction reverses every captured byte, both on the line and in the read-back buffer. A fault in the gap counter or in the sequencer's walk through its states changes the measured high time of `sck` between bytes at the first byte boundary. A fault in the end-of-burst or abort logic shows as an extra or missing `irq`, or as `busy`, `sck` or `sdo` left in the wrong idle state in the cycle after the burst ends.

// File: rtl/ase_pkg.sv
package ase_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_LOAD,
    SQ_SHIFT,
    SQ_GAP
  } seq_state_e;
endpackage

// File: rtl/ase_dpram.sv
module ase_dpram #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             a_we,
  input  logic [AW-1:0]    a_addr,
  input  ase_pkg::byte_t   a_wdata,
  output ase_pkg::byte_t   a_rdata,
  input  logic             b_we,
  input  logic [AW-1:0]    b_addr,
  input  ase_pkg::byte_t   b_wdata,
  output ase_pkg::byte_t   b_rdata
);
  ase_pkg::byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/ase_shift.sv
module ase_shift #(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              idle,
  input  logic              load,
  input  ase_pkg::byte_t    tx,
  input  logic [DIV_W-1:0]  half,
  input  logic              sdi,
  output logic              sck,
  output logic              sdo,
  output logic              done,
  output ase_pkg::byte_t    rx
);
  localparam logic [DIV_W-1:0] ONE_D = DIV_W'(1);

  logic             active;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bitn;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      sck    <= 1'b1;
      sdo    <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      rx     <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        active <= 1'b0;
        sck    <= 1'b1;
        sdo    <= 1'b0;
      end else if (load) begin
        active <= 1'b1;
        sck    <= 1'b1;
        sdo    <= tx[7];
        rx     <= tx;
        cnt    <= '0;
        bitn   <= '0;
      end else if (active) begin
        if (cnt == half - ONE_D) begin
          cnt <= '0;
          if (sck) begin
            // falling edge: present the next bit (the first bit was set at load)
            sck <= 1'b0;
            if (bitn != 3'd0) sdo <= rx[7];
          end else begin
            // rising edge: capture input bit
            sck  <= 1'b1;
            rx   <= {rx[6:0], sdi};
            bitn <= bitn + 3'd1;
            if (bitn == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end
          end
        end else begin
          cnt <= cnt + ONE_D;
        end
      end else if (idle) begin
        sdo <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ase_seq.sv
module ase_seq #(
  parameter int AW    = 5,
  parameter int CNT_W = AW + 1,
  parameter int GAP_W = 8,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [GAP_W-1:0]  gap_cyc,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              irq_ack,
  input  logic              byte_done,
  output logic [AW-1:0]     ptr,
  output logic              ram_we,
  output logic              load,
  output logic [DIV_W-1:0]  half_r,
  output logic              busy,
  output logic              irq,
  output logic              irq_flag
);
  import ase_pkg::*;

  seq_state_e       state;
  logic [CNT_W-1:0] remain;
  logic [GAP_W-1:0] gap_r;
  logic [GAP_W-1:0] gcnt;
  logic             last_byte;

  assign load      = (state == SQ_LOAD);
  assign ram_we    = (state == SQ_SHIFT) && byte_done;
  assign last_byte = (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      ptr      <= '0;
      remain   <= '0;
      gap_r    <= '0;
      gcnt     <= '0;
      half_r   <= DIV_W'(1);
      busy     <= 1'b0;
      irq      <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (irq_ack) irq_flag <= 1'b0;
      if (!en) begin
        state <= SQ_IDLE;
        busy  <= 1'b0;
      end else begin
        unique case (state)
          SQ_IDLE: if (start && byte_cnt != '0) begin
            state  <= SQ_FETCH;
            busy   <= 1'b1;
            ptr    <= '0;
            remain <= byte_cnt;
            gap_r  <= gap_cyc;
            half_r <= half_div;
          end
          SQ_FETCH: state <= SQ_LOAD;
          SQ_LOAD:  state <= SQ_SHIFT;
          SQ_SHIFT: if (byte_done) begin
            ptr <= ptr + AW'(1);
            if (last_byte) begin
              state    <= SQ_IDLE;
              busy     <= 1'b0;
              irq      <= 1'b1;
              irq_flag <= 1'b1;
            end else begin
              state  <= SQ_GAP;
              remain <= remain - CNT_W'(1);
              gcnt   <= '0;
            end
          end
          SQ_GAP: begin
            if (gcnt == gap_r) state <= SQ_FETCH;
            else               gcnt  <= gcnt + GAP_W'(1);
          end
          default: state <= SQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ase_burst_top.sv
module ase_burst_top #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH),
  parameter int CNT_W = AW + 1,
  parameter int GAP_W = 8,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [GAP_W-1:0]  gap_cyc,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              irq_ack,
  input  logic              buf_we,
  input  logic [AW-1:0]     buf_addr,
  input  logic [7:0]        buf_wdata,
  output logic [7:0]        buf_rdata,
  output logic              sck,
  output logic              sdo,
  input  logic              sdi,
  output logic              busy,
  output logic              irq,
  output logic              irq_flag
);
  import ase_pkg::*;

  logic [AW-1:0]    ptr;
  logic             ram_we;
  logic             load;
  logic             byte_done;
  logic [DIV_W-1:0] half_r;
  byte_t            tx_byte;
  byte_t            rx_byte;

  ase_dpram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk     (clk),
    .a_we    (buf_we),
    .a_addr  (buf_addr),
    .a_wdata (buf_wdata),
    .a_rdata (buf_rdata),
    .b_we    (ram_we),
    .b_addr  (ptr),
    .b_wdata (rx_byte),
    .b_rdata (tx_byte)
  );

  ase_seq #(.AW(AW), .CNT_W(CNT_W), .GAP_W(GAP_W), .DIV_W(DIV_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .start     (start),
    .byte_cnt  (byte_cnt),
    .gap_cyc   (gap_cyc),
    .half_div  (half_div),
    .irq_ack   (irq_ack),
    .byte_done (byte_done),
    .ptr       (ptr),
    .ram_we    (ram_we),
    .load      (load),
    .half_r    (half_r),
    .busy      (busy),
    .irq       (irq),
    .irq_flag  (irq_flag)
  );

  ase_shift #(.DIV_W(DIV_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .abort (!en),
    .idle  (!busy),
    .load  (load),
    .tx    (tx_byte),
    .half  (half_r),
    .sdi   (sdi),
    .sck   (sck),
    .sdo   (sdo),
    .done  (byte_done),
    .rx    (rx_byte)
  );
endmodule

// File: rtl/ase_burst_chk.sv
module ase_burst_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic busy,
  input logic sck,
  input logic sdo,
  input logic irq,
  input logic irq_flag,
  input logic irq_ack
);
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) (!busy && !en) |=> !busy); // R3
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst) irq |-> (!busy && $past(busy))); // R4
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) irq |=> !irq); // R4
  AST_FLAG_WITH_IRQ: assert property (@(posedge clk) disable iff (rst) irq |-> irq_flag); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) (irq_flag && !irq_ack) |=> irq_flag); // R5
  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst) !busy |-> sck); // R7
  AST_SDO_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) (!busy && !$past(busy)) |-> !sdo); // R9
endmodule

bind ase_burst_top ase_burst_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .busy     (busy),
  .sck      (sck),
  .sdo      (sdo),
  .irq      (irq),
  .irq_flag (irq_flag),
  .irq_ack  (irq_ack)
);

// File: tb/sim_ase_burst_top.sv
`timescale 1ns/1ps
module sim_ase_burst_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       start = 1'b0;
  logic [5:0] byte_cnt = '0;
  logic [7:0] gap_cyc = '0;
  logic [7:0] half_div = 8'd1;
  logic       irq_ack = 1'b0;
  logic       buf_we = 1'b0;
  logic [4:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0;
  logic [7:0] buf_rdata;
  logic       sck, sdo, sdi, busy, irq, irq_flag;

  assign sdi = ~sdo;

  always #2 clk = ~clk;

  ase_burst_top u0 (
    .clk(clk), .rst(rst), .en(en), .start(start), .byte_cnt(byte_cnt),
    .gap_cyc(gap_cyc), .half_div(half_div), .irq_ack(irq_ack),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .sck(sck), .sdo(sdo), .sdi(sdi),
    .busy(busy), .irq(irq), .irq_flag(irq_flag)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // line monitor
  logic       mon_clr = 1'b1;
  int         exp_gap = 0;
  int         exp_half = 1;
  logic [7:0] cap [64];
  logic [7:0] sh;
  int nb, bits, hi_run, lo_run, gap_bad, clk_bad, irq_cnt, sdo_bad, falls, busy_falls;
  logic prev_sck, prev_busy;

  always @(negedge clk) begin
    if (mon_clr) begin
      nb = 0; bits = 0; hi_run = 0; lo_run = 0; gap_bad = 0; clk_bad = 0;
      irq_cnt = 0; sdo_bad = 0; falls = 0; busy_falls = 0; sh = '0;
    end else begin
      if (irq) irq_cnt++;
      if (prev_busy && !busy) busy_falls++;
      if (!busy && !prev_busy && sdo) sdo_bad++;
      if (prev_sck && !sck) begin
        falls++;
        if (bits > 0) begin
          if (bits % 8 == 0) begin
            if (hi_run != exp_gap) gap_bad++;
          end else if (hi_run != exp_half) clk_bad++;
        end
        lo_run = 1;
      end else if (!prev_sck && sck) begin
        if (lo_run != exp_half) clk_bad++;
        sh = {sh[6:0], sdo};
        bits++;
        if (bits % 8 == 0 && nb < 64) begin
          cap[nb] = sh;
          nb++;
        end
        hi_run = 1;
      end else if (sck) hi_run++;
      else lo_run++;
    end
    prev_sck  = sck;
    prev_busy = busy;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 37 + seed) & 255);
  endfunction

  task automatic clear_mon();
    @(negedge clk) mon_clr = 1'b1;
    @(negedge clk) mon_clr = 1'b0;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      buf_we = 1'b1; buf_addr = 5'(i); buf_wdata = pat(i, seed);
    end
    @(negedge clk) buf_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk) buf_addr = 5'(a);
    @(negedge clk) d = buf_rdata;
  endtask

  task automatic pulse_start(input int n);
    @(negedge clk);
    byte_cnt = 6'(n); start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20000; k++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R6 busy after reset", busy, 0);
    chk(sck == 1'b1, "R7 sck after reset", sck, 1);
    chk(sdo == 1'b0, "R9 sdo after reset", sdo, 0);
    chk(irq == 1'b0 && irq_flag == 1'b0, "R4 irq after reset", irq | irq_flag, 0);
  endtask

  task automatic t_burst(input int n, input int g, input int h, input int seed);
    logic [7:0] d;
    fill(seed);
    clear_mon();
    exp_gap = g + h + 4; exp_half = h;
    en = 1'b1; gap_cyc = 8'(g); half_div = 8'(h);
    pulse_start(n);
    chk(busy == 1'b1, "R6 busy after start", busy, 1);
    wait_idle();
    chk(irq == 1'b1, "R4 irq with busy fall", irq, 1);
    chk(irq_flag == 1'b1, "R5 flag set", irq_flag, 1);
    repeat (3) @(negedge clk);
    chk(nb == n, "R1 byte count", nb, n);
    for (int i = 0; i < n && i < 64; i++)
      chk(cap[i] == pat(i, seed), "R1 tx byte", cap[i], pat(i, seed));
    chk(clk_bad == 0, "R7 sck phase length", clk_bad, 0);
    chk(gap_bad == 0, "R8 inter-byte gap", gap_bad, 0);
    chk(irq_cnt == 1, "R4 one irq", irq_cnt, 1);
    chk(busy_falls == 1, "R6 busy single fall", busy_falls, 1);
    chk(sdo_bad == 0 && sdo == 1'b0, "R9 sdo idle low", sdo_bad + int'(sdo), 0);
    for (int i = 0; i < n; i++) begin
      rd(i, d);
      chk(d == ~pat(i, seed), "R2 rx written back", d, ~pat(i, seed));
    end
    if (n < 32) begin
      rd(n, d);
      chk(d == pat(n, seed), "R2 untouched above count", d, pat(n, seed));
    end
  endtask

  task automatic t_ack();
    repeat (5) @(negedge clk);
    chk(irq_flag == 1'b1, "R5 flag sticky", irq_flag, 1);
    irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
    chk(irq_flag == 1'b0, "R5 flag cleared by ack", irq_flag, 0);
  endtask

  task automatic t_disabled_start();
    clear_mon();
    en = 1'b0;
    pulse_start(4);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R3 no busy when disabled", busy, 0);
    chk(falls == 0 && sck == 1'b1, "R3 no sck activity", falls, 0);
    en = 1'b1;
  endtask

  task automatic t_zero_count();
    clear_mon();
    en = 1'b1;
    pulse_start(0);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R12 zero count no busy", busy, 0);
    chk(falls == 0, "R12 zero count no sck", falls, 0);
  endtask

  task automatic t_retrigger();
    fill(91);
    clear_mon();
    exp_gap = 2 + 1 + 4; exp_half = 1;
    en = 1'b1; gap_cyc = 8'd2; half_div = 8'd1;
    pulse_start(3);
    for (int k = 0; k < 1000 && nb < 1; k++) @(negedge clk);
    pulse_start(5);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(nb == 3, "R10 retrigger ignored length", nb, 3);
    chk(irq_cnt == 1, "R10 single irq", irq_cnt, 1);
  endtask

  task automatic t_abort();
    fill(7);
    clear_mon();
    exp_gap = 10 + 2 + 4; exp_half = 2;
    en = 1'b1; gap_cyc = 8'd10; half_div = 8'd2;
    pulse_start(4);
    for (int k = 0; k < 1000 && nb < 1; k++) @(negedge clk);
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R11 abort busy", busy, 0);
    chk(sck == 1'b1, "R11 abort sck", sck, 1);
    chk(sdo == 1'b0, "R11 abort sdo", sdo, 0);
    repeat (40) @(negedge clk);
    chk(irq_cnt == 0, "R11 no irq after abort", irq_cnt, 0);
    chk(nb == 1, "R11 no bytes after abort", nb, 1);
    en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_burst(1, 0, 1, 3);
    t_ack();
    t_burst(5, 3, 2, 11);
    t_burst(32, 0, 1, 200);
    t_ack();
    t_burst(2, 7, 3, 55);
    t_disabled_start();
    t_zero_count();
    t_retrigger();
    t_abort();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule